// File: doc/BRIEF.md
# Bus Parity Generate and Check Controller

This block supplies the parity layer of a registered bidirectional transceiver whose two ports, A and B, each carry a number of byte-wide groups with one parity bit per group. It sits beside the storage stage: it receives the stored words travelling towards each port, the live words and parity bits arriving on each port, and the control inputs. From these it produces the values and drive enables for data and parity on each port, plus one active-low error flag per group and port, with its own drive enable.

A disable input switches the parity layer off. In that case stored parity bits travel with their data unchanged, and each direction enable simply gates its port. With parity on, the two active-low direction enables assign roles. Enabling only one direction drives the destination port with freshly generated parity and checks the source port. Enabling neither direction checks both ports. Enabling both directions generates parity onto both ports. A polarity input selects even or odd parity for both generation and checking. Every output is registered once, so results follow the sampled inputs by one clock.

Top module: `ptx_parity_ctl`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves every drive enable low, every data and parity output at zero, and every error flag at one.
- R2: With `par_off` high, a low `ab_drv_n` drives port B with `qa_word` and with `qa_par` unchanged, and a low `ba_drv_n` drives port A with `qb_word` and with `qb_par` unchanged. Both directions may drive at once.
- R3: A port that is not driven (`a_oe`/`b_oe` low) shows zero on its data and parity outputs. With `par_off` high and both direction enables high, neither port is driven.
- R4: With `par_off` high, both error-flag enables are low. A released error flag shows all ones, whatever parity the live buses carry.
- R5: With `par_off` low, `ab_drv_n` low and `ba_drv_n` high, port B is driven with `qa_word` and generated parity, port A is checked, port B's flags are released, and port A is not driven.
- R6: With `par_off` low, `ba_drv_n` low and `ab_drv_n` high, port A is driven with `qb_word` and generated parity, port B is checked, port A's flags are released, and port B is not driven.
- R7: With `par_off` low and both direction enables high, both ports are checked and neither port is driven.
- R8: With `par_off` low and both direction enables low, both ports are driven with generated parity and all error flags are released.
- R9: With `odd_sel` low, a generated bit is the XOR of its group's 8 data bits, which makes the 9-bit total even. With `odd_sel` high, it is the complement, which makes the total odd. Group g takes data bits [8g+7:8g] and parity bit g.
- R10: A checked flag bit g is low exactly when group g's 8 live data bits plus live parity bit g hold an odd count of ones under even polarity, or an even count under odd polarity. Each group is judged on its own.
- R11: Every output reflects the inputs sampled at the previous rising edge. An input change between edges does not alter the outputs before the next edge.
- R12: When parity is generated, the stored parity inputs (`qa_par`, `qb_par`) have no effect on the parity outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_off | input | 1 | High disables parity functions |
| odd_sel | input | 1 | Low even, high odd parity |
| ab_drv_n | input | 1 | Active-low enable for driving port B |
| ba_drv_n | input | 1 | Active-low enable for driving port A |
| a_bus | input | GROUPS*GRP_W | Live data arriving on port A |
| a_bpar | input | GROUPS | Live parity arriving on port A |
| b_bus | input | GROUPS*GRP_W | Live data arriving on port B |
| b_bpar | input | GROUPS | Live parity arriving on port B |
| qa_word | input | GROUPS*GRP_W | Stored word heading to port B |
| qa_par | input | GROUPS | Stored parity heading to port B |
| qb_word | input | GROUPS*GRP_W | Stored word heading to port A |
| qb_par | input | GROUPS | Stored parity heading to port A |
| a_dout | output | GROUPS*GRP_W | Data value for port A |
| a_pout | output | GROUPS | Parity value for port A |
| a_oe | output | 1 | Drive enable for port A data and parity |
| b_dout | output | GROUPS*GRP_W | Data value for port B |
| b_pout | output | GROUPS | Parity value for port B |
| b_oe | output | 1 | Drive enable for port B data and parity |
| err_a_n | output | GROUPS | Active-low parity error flags, port A |
| err_a_oe | output | 1 | Drive enable of port A flags |
| err_b_n | output | GROUPS | Active-low parity error flags, port B |
| err_b_oe | output | 1 | Drive enable of port B flags |

## Verification
The hardest case to provoke is one group failing while its neighbour passes, under each polarity, in a mode where the error flags are actually driven. Pseudo-random words alone rarely isolate it. The stimulus therefore sets up check-only and single-direction modes with hand-built words: one group's parity bit is deliberately wrong and the other's is right, and then the roles are swapped. A second subtle case is generation ignoring stale stored parity. The bench repeats the same stored word with opposite stored parity bits and expects identical generated outputs.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int DEF_GROUPS = 2;
    localparam int DEF_GRP_W  = 8;

    // Which directions are enabled, high meaning driven: {to A, to B}
    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_TO_B = 2'b01,
        MODE_TO_A = 2'b10,
        MODE_BOTH = 2'b11
    } dir_e;

    typedef struct packed {
        logic drv_a;
        logic drv_b;
        logic chk_a;
        logic chk_b;
        logic gen;
    } role_t;

    function automatic dir_e dir_of(input logic ab_n, input logic ba_n);
        return dir_e'({~ba_n, ~ab_n});
    endfunction

endpackage

// File: rtl/ptx_role_dec.sv
module ptx_role_dec
    import ptx_pkg::*;
(
    input  logic  par_off,
    input  logic  ab_drv_n,
    input  logic  ba_drv_n,
    output role_t role
);
    dir_e dir;

    always_comb begin
        dir      = dir_of(ab_drv_n, ba_drv_n);
        role     = '0;
        role.gen = ~par_off;
        case (dir)
            MODE_TO_B: begin
                role.drv_b = 1'b1;
                role.chk_a = ~par_off;
            end
            MODE_TO_A: begin
                role.drv_a = 1'b1;
                role.chk_b = ~par_off;
            end
            MODE_NONE: begin
                role.chk_a = ~par_off;
                role.chk_b = ~par_off;
            end
            MODE_BOTH: begin
                role.drv_a = 1'b1;
                role.drv_b = 1'b1;
            end
            default: role = '0;
        endcase
    end
endmodule

// File: rtl/ptx_par_lane.sv
module ptx_par_lane #(
    parameter int GRP_W = ptx_pkg::DEF_GRP_W
) (
    input  logic [GRP_W-1:0] word,
    input  logic             par_in,
    input  logic             gen,
    input  logic             odd_sel,
    input  logic             drive,
    output logic [GRP_W-1:0] word_o,
    output logic             par_o
);
    logic gen_bit;

    always_comb begin
        gen_bit = (^word) ^ odd_sel;
        word_o  = drive ? word : '0;
        if (!drive)   par_o = 1'b0;
        else if (gen) par_o = gen_bit;
        else          par_o = par_in;
    end
endmodule

// File: rtl/ptx_par_chk.sv
module ptx_par_chk #(
    parameter int GRP_W = ptx_pkg::DEF_GRP_W
) (
    input  logic [GRP_W-1:0] word,
    input  logic             par_in,
    input  logic             odd_sel,
    input  logic             enable,
    output logic             err_n
);
    logic total;

    always_comb begin
        total = ^{word, par_in};
        // pass when total parity equals the selected polarity
        err_n = enable ? (total == odd_sel) : 1'b1;
    end
endmodule

// File: rtl/ptx_parity_ctl.sv
module ptx_parity_ctl
    import ptx_pkg::*;
#(
    parameter int GROUPS = DEF_GROUPS,
    parameter int GRP_W  = DEF_GRP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    par_off,
    input  logic                    odd_sel,
    input  logic                    ab_drv_n,
    input  logic                    ba_drv_n,
    input  logic [GROUPS*GRP_W-1:0] a_bus,
    input  logic [GROUPS-1:0]       a_bpar,
    input  logic [GROUPS*GRP_W-1:0] b_bus,
    input  logic [GROUPS-1:0]       b_bpar,
    input  logic [GROUPS*GRP_W-1:0] qa_word,
    input  logic [GROUPS-1:0]       qa_par,
    input  logic [GROUPS*GRP_W-1:0] qb_word,
    input  logic [GROUPS-1:0]       qb_par,
    output logic [GROUPS*GRP_W-1:0] a_dout,
    output logic [GROUPS-1:0]       a_pout,
    output logic                    a_oe,
    output logic [GROUPS*GRP_W-1:0] b_dout,
    output logic [GROUPS-1:0]       b_pout,
    output logic                    b_oe,
    output logic [GROUPS-1:0]       err_a_n,
    output logic                    err_a_oe,
    output logic [GROUPS-1:0]       err_b_n,
    output logic                    err_b_oe
);
    localparam int BUS_W = GROUPS * GRP_W;

    role_t              role;
    logic [BUS_W-1:0]   nxt_a_dout, nxt_b_dout;
    logic [GROUPS-1:0]  nxt_a_pout, nxt_b_pout;
    logic [GROUPS-1:0]  nxt_err_a, nxt_err_b;

    ptx_role_dec u_dec (
        .par_off  (par_off),
        .ab_drv_n (ab_drv_n),
        .ba_drv_n (ba_drv_n),
        .role     (role)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ptx_par_lane #(.GRP_W(GRP_W)) u_to_b (
            .word    (qa_word[g*GRP_W +: GRP_W]),
            .par_in  (qa_par[g]),
            .gen     (role.gen),
            .odd_sel (odd_sel),
            .drive   (role.drv_b),
            .word_o  (nxt_b_dout[g*GRP_W +: GRP_W]),
            .par_o   (nxt_b_pout[g])
        );
        ptx_par_lane #(.GRP_W(GRP_W)) u_to_a (
            .word    (qb_word[g*GRP_W +: GRP_W]),
            .par_in  (qb_par[g]),
            .gen     (role.gen),
            .odd_sel (odd_sel),
            .drive   (role.drv_a),
            .word_o  (nxt_a_dout[g*GRP_W +: GRP_W]),
            .par_o   (nxt_a_pout[g])
        );
        ptx_par_chk #(.GRP_W(GRP_W)) u_chk_a (
            .word    (a_bus[g*GRP_W +: GRP_W]),
            .par_in  (a_bpar[g]),
            .odd_sel (odd_sel),
            .enable  (role.chk_a),
            .err_n   (nxt_err_a[g])
        );
        ptx_par_chk #(.GRP_W(GRP_W)) u_chk_b (
            .word    (b_bus[g*GRP_W +: GRP_W]),
            .par_in  (b_bpar[g]),
            .odd_sel (odd_sel),
            .enable  (role.chk_b),
            .err_n   (nxt_err_b[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_dout   <= '0;
            a_pout   <= '0;
            a_oe     <= 1'b0;
            b_dout   <= '0;
            b_pout   <= '0;
            b_oe     <= 1'b0;
            err_a_n  <= '1;
            err_a_oe <= 1'b0;
            err_b_n  <= '1;
            err_b_oe <= 1'b0;
        end else begin
            a_dout   <= nxt_a_dout;
            a_pout   <= nxt_a_pout;
            a_oe     <= role.drv_a;
            b_dout   <= nxt_b_dout;
            b_pout   <= nxt_b_pout;
            b_oe     <= role.drv_b;
            err_a_n  <= nxt_err_a;
            err_a_oe <= role.chk_a;
            err_b_n  <= nxt_err_b;
            err_b_oe <= role.chk_b;
        end
    end
endmodule

// File: rtl/ptx_parity_ctl_chk.sv
module ptx_parity_ctl_chk #(
    parameter int GROUPS = ptx_pkg::DEF_GROUPS,
    parameter int GRP_W  = ptx_pkg::DEF_GRP_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    par_off,
    input logic                    ab_drv_n,
    input logic                    ba_drv_n,
    input logic [GROUPS*GRP_W-1:0] qa_word,
    input logic [GROUPS-1:0]       qa_par,
    input logic [GROUPS*GRP_W-1:0] qb_word,
    input logic [GROUPS-1:0]       qb_par,
    input logic [GROUPS*GRP_W-1:0] a_dout,
    input logic [GROUPS-1:0]       a_pout,
    input logic                    a_oe,
    input logic [GROUPS*GRP_W-1:0] b_dout,
    input logic [GROUPS-1:0]       b_pout,
    input logic                    b_oe,
    input logic [GROUPS-1:0]       err_a_n,
    input logic                    err_a_oe,
    input logic [GROUPS-1:0]       err_b_n,
    input logic                    err_b_oe
);
    AST_PASS_TO_B: assert property (@(posedge clk) disable iff (rst)
        par_off && !ab_drv_n |=> b_oe && b_dout == $past(qa_word) && b_pout == $past(qa_par)); // R2
    AST_PASS_TO_A: assert property (@(posedge clk) disable iff (rst)
        par_off && !ba_drv_n |=> a_oe && a_dout == $past(qb_word) && a_pout == $past(qb_par)); // R2
    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        par_off && ab_drv_n && ba_drv_n |=> !a_oe && !b_oe); // R3
    AST_IDLE_A_ZERO: assert property (@(posedge clk) disable iff (rst)
        !a_oe |-> a_dout == '0 && a_pout == '0); // R3
    AST_IDLE_B_ZERO: assert property (@(posedge clk) disable iff (rst)
        !b_oe |-> b_dout == '0 && b_pout == '0); // R3
    AST_OFF_FLAGS_REL: assert property (@(posedge clk) disable iff (rst)
        par_off |=> !err_a_oe && !err_b_oe); // R4
    AST_REL_A_HIGH: assert property (@(posedge clk) disable iff (rst)
        !err_a_oe |-> &err_a_n); // R4
    AST_REL_B_HIGH: assert property (@(posedge clk) disable iff (rst)
        !err_b_oe |-> &err_b_n); // R4
    AST_ROLE_TO_B: assert property (@(posedge clk) disable iff (rst)
        !par_off && !ab_drv_n && ba_drv_n |=> b_oe && !a_oe && err_a_oe && !err_b_oe); // R5
    AST_ROLE_TO_A: assert property (@(posedge clk) disable iff (rst)
        !par_off && ab_drv_n && !ba_drv_n |=> a_oe && !b_oe && err_b_oe && !err_a_oe); // R6
    AST_CHECK_BOTH: assert property (@(posedge clk) disable iff (rst)
        !par_off && ab_drv_n && ba_drv_n |=> err_a_oe && err_b_oe && !a_oe && !b_oe); // R7
    AST_GEN_BOTH: assert property (@(posedge clk) disable iff (rst)
        !par_off && !ab_drv_n && !ba_drv_n |=> a_oe && b_oe && !err_a_oe && !err_b_oe); // R8
endmodule

bind ptx_parity_ctl ptx_parity_ctl_chk #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_chk (
    .clk(clk), .rst(rst), .par_off(par_off), .ab_drv_n(ab_drv_n), .ba_drv_n(ba_drv_n),
    .qa_word(qa_word), .qa_par(qa_par), .qb_word(qb_word), .qb_par(qb_par),
    .a_dout(a_dout), .a_pout(a_pout), .a_oe(a_oe),
    .b_dout(b_dout), .b_pout(b_pout), .b_oe(b_oe),
    .err_a_n(err_a_n), .err_a_oe(err_a_oe), .err_b_n(err_b_n), .err_b_oe(err_b_oe)
);

// File: tb/sim_ptx_parity_ctl.sv
module sim_ptx_parity_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int G  = 2;
    localparam int W  = 8;
    localparam int N  = G * W;
    localparam int VW = 2 * N + 4 * G + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic par_off = 1'b0, odd_sel = 1'b0, ab_n = 1'b0, ba_n = 1'b0;
    logic [N-1:0] a_bus = '0, b_bus = '0, qa_word = '0, qb_word = '0;
    logic [G-1:0] a_bpar = '0, b_bpar = '0, qa_par = '0, qb_par = '0;

    logic [N-1:0] a_dout, b_dout;
    logic [G-1:0] a_pout, b_pout, err_a_n, err_b_n;
    logic a_oe, b_oe, err_a_oe, err_b_oe;

    int checks = 0;
    int errors = 0;
    logic [VW-1:0] exp_q[$];
    string         tag_q[$];
    logic [VW-1:0] last_exp;
    logic [31:0]   seed = 32'h1F2E3D4C;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptx_parity_ctl #(.GROUPS(G), .GRP_W(W)) u0 (
        .clk(clk), .rst(rst), .par_off(par_off), .odd_sel(odd_sel),
        .ab_drv_n(ab_n), .ba_drv_n(ba_n),
        .a_bus(a_bus), .a_bpar(a_bpar), .b_bus(b_bus), .b_bpar(b_bpar),
        .qa_word(qa_word), .qa_par(qa_par), .qb_word(qb_word), .qb_par(qb_par),
        .a_dout(a_dout), .a_pout(a_pout), .a_oe(a_oe),
        .b_dout(b_dout), .b_pout(b_pout), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_a_oe(err_a_oe), .err_b_n(err_b_n), .err_b_oe(err_b_oe)
    );

    wire [VW-1:0] obs = {a_dout, a_pout, a_oe, b_dout, b_pout, b_oe,
                         err_a_n, err_a_oe, err_b_n, err_b_oe};

    function automatic logic gen_bit(input logic [W-1:0] d, input logic odd);
        return ((($countones(d) % 2) == 1) ? 1'b1 : 1'b0) ^ odd;
    endfunction

    function automatic logic flag_n(input logic [W-1:0] d, input logic p, input logic odd);
        int total;
        total = $countones(d) + int'(p);
        return ((total % 2) == int'(odd)) ? 1'b1 : 1'b0;
    endfunction

    // Expected outputs derived from the requirements
    function automatic logic [VW-1:0] model();
        logic [N-1:0] ad, bd;
        logic [G-1:0] ap, bp, ea, eb;
        logic aoe, boe, eao, ebo;
        aoe = !ba_n;
        boe = !ab_n;
        eao = !par_off && ba_n;
        ebo = !par_off && ab_n;
        ad = aoe ? qb_word : '0;
        bd = boe ? qa_word : '0;
        for (int g = 0; g < G; g++) begin
            ap[g] = !aoe ? 1'b0 : (par_off ? qb_par[g] : gen_bit(qb_word[g*W +: W], odd_sel));
            bp[g] = !boe ? 1'b0 : (par_off ? qa_par[g] : gen_bit(qa_word[g*W +: W], odd_sel));
            ea[g] = eao ? flag_n(a_bus[g*W +: W], a_bpar[g], odd_sel) : 1'b1;
            eb[g] = ebo ? flag_n(b_bus[g*W +: W], b_bpar[g], odd_sel) : 1'b1;
        end
        return {ad, ap, aoe, bd, bp, boe, ea, eao, eb, ebo};
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_in(input logic off, input logic odd, input logic abn, input logic ban,
                          input logic [N-1:0] abus, input logic [G-1:0] apar,
                          input logic [N-1:0] bbus, input logic [G-1:0] bpar,
                          input logic [N-1:0] qaw, input logic [G-1:0] qap,
                          input logic [N-1:0] qbw, input logic [G-1:0] qbp);
        par_off = off; odd_sel = odd; ab_n = abn; ba_n = ban;
        a_bus = abus; a_bpar = apar; b_bus = bbus; b_bpar = bpar;
        qa_word = qaw; qa_par = qap; qb_word = qbw; qb_par = qbp;
    endtask

    // Driver: applies one item at a falling edge and queues its expectation
    task automatic item(input string tag, input logic off, input logic odd, input logic abn,
                        input logic ban, input logic [N-1:0] abus, input logic [G-1:0] apar,
                        input logic [N-1:0] bbus, input logic [G-1:0] bpar,
                        input logic [N-1:0] qaw, input logic [G-1:0] qap,
                        input logic [N-1:0] qbw, input logic [G-1:0] qbp);
        @(negedge clk);
        set_in(off, odd, abn, ban, abus, apar, bbus, bpar, qaw, qap, qbw, qbp);
        last_exp = model();
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            logic [VW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, obs, e);
        end
    end

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    initial begin
        #(CLK_PERIOD * 4000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset with an active-looking input set
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 16'h0101, 2'b00, 16'h0303, 2'b11,
               16'hFFFF, 2'b11, 16'h1234, 2'b01);
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1 reset outputs", obs, {{N{1'b0}}, {G{1'b0}}, 1'b0, {N{1'b0}}, {G{1'b0}}, 1'b0,
                                        {G{1'b1}}, 1'b0, {G{1'b1}}, 1'b0});
        set_in(1'b0, 1'b0, 1'b1, 1'b1, 16'h0100, 2'b00, 16'h0001, 2'b00,
               16'h0, 2'b0, 16'h0, 2'b0);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1 reset holds flags", obs, {{N{1'b0}}, {G{1'b0}}, 1'b0, {N{1'b0}}, {G{1'b0}}, 1'b0,
                                            {G{1'b1}}, 1'b0, {G{1'b1}}, 1'b0});
        @(negedge clk);
        rst = 1'b0;

        // R2: feed-through, both directions and one direction
        item("R2", 1, 0, 0, 0, 16'h0, 2'b0, 16'h0, 2'b0, 16'hA55A, 2'b10, 16'h0F01, 2'b01);
        item("R2", 1, 1, 0, 1, 16'h0, 2'b0, 16'h0, 2'b0, 16'h8001, 2'b11, 16'hFFFF, 2'b00);
        item("R2", 1, 0, 1, 0, 16'h0, 2'b0, 16'h0, 2'b0, 16'h1111, 2'b00, 16'h7E81, 2'b10);
        // R3: isolation
        item("R3", 1, 0, 1, 1, 16'h0101, 2'b00, 16'h0303, 2'b01, 16'hFFFF, 2'b11, 16'hFFFF, 2'b11);
        // R4: flags released despite bad live parity
        item("R4", 1, 0, 1, 0, 16'h0101, 2'b00, 16'h0100, 2'b00, 16'h2222, 2'b01, 16'h4444, 2'b10);
        item("R4", 1, 1, 1, 1, 16'h0000, 2'b00, 16'h0000, 2'b00, 16'h0, 2'b00, 16'h0, 2'b00);
        // R5: drive B, check A; group0 bad, group1 good under even
        item("R5", 0, 0, 0, 1, 16'h0301, 2'b00, 16'h0101, 2'b00, 16'h00FF, 2'b11, 16'h0, 2'b0);
        item("R5", 0, 1, 0, 1, 16'h0301, 2'b00, 16'h0, 2'b00, 16'h0100, 2'b00, 16'h0, 2'b0);
        // R6: drive A, check B under odd
        item("R6", 0, 1, 1, 0, 16'h0101, 2'b00, 16'h0701, 2'b10, 16'h0, 2'b0, 16'hC3F0, 2'b11);
        item("R6", 0, 0, 1, 0, 16'h0, 2'b00, 16'h0701, 2'b10, 16'h0, 2'b0, 16'h0080, 2'b00);
        // R7: check both ports
        item("R7", 0, 0, 1, 1, 16'h0100, 2'b10, 16'h0001, 2'b10, 16'hFFFF, 2'b11, 16'hFFFF, 2'b11);
        item("R7", 0, 1, 1, 1, 16'hFF00, 2'b00, 16'h00FF, 2'b11, 16'h0, 2'b0, 16'h0, 2'b0);
        // R8: generate both
        item("R8", 0, 0, 0, 0, 16'h0101, 2'b11, 16'h0101, 2'b00, 16'h0F07, 2'b00, 16'hF0E1, 2'b11);
        item("R8", 0, 1, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, 16'h0F07, 2'b00, 16'hF0E1, 2'b11);
        // R9: generation on extreme words, both polarities
        item("R9", 0, 0, 0, 1, 16'h0, 2'b0, 16'h0, 2'b0, 16'hFF00, 2'b00, 16'h0, 2'b0);
        item("R9", 0, 1, 0, 1, 16'h0, 2'b0, 16'h0, 2'b0, 16'hFF00, 2'b00, 16'h0, 2'b0);
        item("R9", 0, 1, 1, 0, 16'h0, 2'b0, 16'h0, 2'b0, 16'h0, 2'b0, 16'h8001, 2'b00);
        // R10: group independence, swapping which group fails
        item("R10", 0, 0, 1, 1, 16'h0100, 2'b00, 16'h0001, 2'b00, 16'h0, 2'b0, 16'h0, 2'b0);
        item("R10", 0, 0, 1, 1, 16'h0001, 2'b00, 16'h0100, 2'b00, 16'h0, 2'b0, 16'h0, 2'b0);
        item("R10", 0, 1, 1, 1, 16'h0100, 2'b01, 16'h0001, 2'b10, 16'h0, 2'b0, 16'h0, 2'b0);
        // R12: stored parity must not change generated bits
        item("R12", 0, 0, 0, 0, 16'h0, 2'b0, 16'h0, 2'b0, 16'h3C81, 2'b00, 16'h5A07, 2'b00);
        item("R12", 0, 0, 0, 0, 16'h0, 2'b0, 16'h0, 2'b0, 16'h3C81, 2'b11, 16'h5A07, 2'b11);
        // Mixed pseudo-random traffic, tag chosen by mode
        for (int i = 0; i < 48; i++) begin
            logic [31:0] r0, r1, r2;
            string t;
            r0 = rnd(); r1 = rnd(); r2 = rnd();
            if (r0[0]) t = (r0[2] && r0[3]) ? "R3" : "R2";
            else if (!r0[2] && r0[3]) t = "R5";
            else if (r0[2] && !r0[3]) t = "R6";
            else if (r0[2] && r0[3]) t = "R7";
            else t = "R8";
            item(t, r0[0], r0[1], r0[2], r0[3], r1[15:0], r0[5:4], r1[31:16], r0[7:6],
                 r2[15:0], r0[9:8], r2[31:16], r0[11:10]);
        end
        repeat (3) @(posedge clk);

        // R11: a change between edges leaves outputs alone until the next edge
        @(negedge clk);
        set_in(0, 1, 1, 1, 16'h0001, 2'b00, 16'h0100, 2'b00, 16'h0, 2'b0, 16'h0, 2'b0);
        #1;
        check("R11 before edge", obs, last_exp);
        last_exp = model();
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R11 after edge", obs, last_exp);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule